// File: doc/BRIEF.md
# Priority Interrupt Source Arbiter

This block picks one winning interrupt line out of up to three banks of 32 lines each. It keeps a separate winner for each of two request classes: the normal class and the fast class. For every line it receives a pending bit, a mask bit, a class-select bit and a priority number. It compares all eligible lines in a balanced tree, so the winner is ready within a single cycle.

Each class has its own capture strobe. A strobe loads the current winner of that class into the class's active-source register, which then holds its value until the next strobe for the same class. The surrounding controller owns register access, input latching and the request outputs. This block only computes and holds the source numbers.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A line competes in the normal class only when its pending bit is 1, its mask bit is 0 and its class-select bit is 0.
- R2: A line competes in the fast class only when its pending bit is 1, its mask bit is 0 and its class-select bit is 1.
- R3: Among the competing lines of a class, the line with the numerically smallest priority wins, so priority 0 is the most urgent.
- R4: When competing lines share the smallest priority, the line with the highest global index wins, including across bank boundaries.
- R5: The reported source number is the global line index, which is 32 × bank + bit position. Line g uses pend_i[g] and prio_i[g*PRIO_W +: PRIO_W].
- R6: A capture strobe for a class with no competing line loads 0 into that class's register.
- R7: An active-source register changes only on the clock edge at which its own capture strobe is high. Otherwise it holds its value, whatever the inputs or the other class's strobe do.
- R8: Reset clears both active-source registers to 0.
- R9: When both strobes are high in the same cycle, each register loads its own class's winner independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_BANKS*32 | Pending bit per line |
| mask_i | input | NUM_BANKS*32 | Mask bit per line; 1 excludes the line |
| fast_sel_i | input | NUM_BANKS*32 | Class select per line; 1 selects the fast class |
| prio_i | input | NUM_BANKS*32*PRIO_W | Priority per line; 0 is the most urgent |
| cap_norm_i | input | 1 | Capture strobe for the normal-class register |
| cap_fast_i | input | 1 | Capture strobe for the fast-class register |
| src_norm_o | output | clog2(NUM_BANKS*32) | Active source number, normal class |
| src_fast_o | output | clog2(NUM_BANKS*32) | Active source number, fast class |

## Verification
The hardest case to reach is a tie that spans banks while many lines compete at once, because the order of the tree's comparisons only shows up there. The bench fills all 96 lines as pending at the least urgent priority, so the top line must win. It then places equal-priority lines on both sides of the 31/32 boundary and inside bank 2. It also strobes one class at a time after the inputs change, which shows that the other register holds its value.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int LINES_PER_BANK = 32;
   localparam int MAX_BANKS      = 3;

   typedef enum logic {
      CLS_NORM = 1'b0,
      CLS_FAST = 1'b1
   } irq_cls_e;
endpackage

// File: rtl/irq_cand_filter.sv
module irq_cand_filter
   import irq_arb_pkg::*;
#(
   parameter int       N   = 96,
   parameter irq_cls_e CLS = CLS_NORM
) (
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] mask_i,
   input  logic [N-1:0] fast_sel_i,
   output logic [N-1:0] cand_o
);
   generate
      if (CLS == CLS_FAST) begin : g_fast
         assign cand_o = pend_i & ~mask_i & fast_sel_i;
      end else begin : g_norm
         assign cand_o = pend_i & ~mask_i & ~fast_sel_i;
      end
   endgenerate
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
   parameter int N  = 96,
   parameter int PW = 6,
   localparam int IW = (N > 1) ? $clog2(N) : 1,
   localparam int P  = 1 << IW,
   localparam int NODES = 2 * P - 1
) (
   input  logic [N-1:0]    cand_i,
   input  logic [N*PW-1:0] prio_i,
   output logic            win_v_o,
   output logic [IW-1:0]   win_idx_o
);
   logic          nv [NODES];
   logic [PW-1:0] np [NODES];
   logic [IW-1:0] ni [NODES];

   // leaves: heap slot P-1+i holds line i; padding lines never compete
   for (genvar i = 0; i < P; i++) begin : g_leaf
      if (i < N) begin : g_real
         assign nv[P-1+i] = cand_i[i];
         assign np[P-1+i] = prio_i[i*PW +: PW];
         assign ni[P-1+i] = IW'(i);
      end else begin : g_pad
         assign nv[P-1+i] = 1'b0;
         assign np[P-1+i] = '1;
         assign ni[P-1+i] = IW'(i);
      end
   end

   // inner nodes: the right child covers higher indices and wins ties
   for (genvar k = 0; k < P - 1; k++) begin : g_node
      localparam int L = 2 * k + 1;
      localparam int R = 2 * k + 2;
      logic take_r;
      assign take_r = nv[R] && (!nv[L] || (np[R] <= np[L]));
      assign nv[k]  = nv[L] | nv[R];
      assign np[k]  = take_r ? np[R] : np[L];
      assign ni[k]  = take_r ? ni[R] : ni[L];
   end

   assign win_v_o   = nv[0];
   assign win_idx_o = ni[0];
endmodule

// File: rtl/irq_src_hold.sv
module irq_src_hold #(
   parameter int IW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_i,
   input  logic          win_v_i,
   input  logic [IW-1:0] win_idx_i,
   output logic [IW-1:0] src_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_o <= '0;
      end else if (cap_i) begin
         src_o <= win_v_i ? win_idx_i : '0;
      end
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int PRIO_W    = 6,
   localparam int N  = NUM_BANKS * LINES_PER_BANK,
   localparam int IW = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      pend_i,
   input  logic [N-1:0]      mask_i,
   input  logic [N-1:0]      fast_sel_i,
   input  logic [N*PRIO_W-1:0] prio_i,
   input  logic              cap_norm_i,
   input  logic              cap_fast_i,
   output logic [IW-1:0]     src_norm_o,
   output logic [IW-1:0]     src_fast_o
);
   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("irq_prio_arbiter: NUM_BANKS must be 1..3");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("irq_prio_arbiter: PRIO_W must be 1..8");
   end

   logic [1:0]    cap;
   logic [IW-1:0] src_q [2];

   assign cap = {cap_fast_i, cap_norm_i};

   for (genvar c = 0; c < 2; c++) begin : g_cls
      localparam irq_cls_e CLS = (c == 1) ? CLS_FAST : CLS_NORM;
      logic [N-1:0]  cand;
      logic          win_v;
      logic [IW-1:0] win_idx;

      irq_cand_filter #(.N(N), .CLS(CLS)) u_filt (
         .pend_i    (pend_i),
         .mask_i    (mask_i),
         .fast_sel_i(fast_sel_i),
         .cand_o    (cand)
      );

      irq_prio_tree #(.N(N), .PW(PRIO_W)) u_tree (
         .cand_i   (cand),
         .prio_i   (prio_i),
         .win_v_o  (win_v),
         .win_idx_o(win_idx)
      );

      irq_src_hold #(.IW(IW)) u_hold (
         .clk      (clk),
         .rst_n    (rst_n),
         .cap_i    (cap[c]),
         .win_v_i  (win_v),
         .win_idx_i(win_idx),
         .src_o    (src_q[c])
      );
   end

   assign src_norm_o = src_q[0];
   assign src_fast_o = src_q[1];
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
   parameter int NUM_BANKS = 3,
   localparam int N  = NUM_BANKS * 32,
   localparam int IW = $clog2(N)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [N-1:0]  pend_i,
   input logic [N-1:0]  mask_i,
   input logic [N-1:0]  fast_sel_i,
   input logic          cap_norm_i,
   input logic          cap_fast_i,
   input logic [IW-1:0] src_norm_o,
   input logic [IW-1:0] src_fast_o
);
   logic [N-1:0] elig_n, elig_f, elig_n_q, elig_f_q;

   assign elig_n = pend_i & ~mask_i & ~fast_sel_i;
   assign elig_f = pend_i & ~mask_i & fast_sel_i;

   always_ff @(posedge clk) begin
      elig_n_q <= elig_n;
      elig_f_q <= elig_f;
   end

   AST_NORM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_norm_i |=> $stable(src_norm_o)); // R7
   AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_fast_i |=> $stable(src_fast_o)); // R7
   AST_NORM_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_norm_i && elig_n == '0) |=> src_norm_o == '0); // R6
   AST_FAST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_fast_i && elig_f == '0) |=> src_fast_o == '0); // R6
   AST_NORM_WINNER_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_norm_i && elig_n != '0) |=> elig_n_q[src_norm_o]); // R1
   AST_FAST_WINNER_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_fast_i && elig_f != '0) |=> elig_f_q[src_fast_o]); // R2
   AST_NORM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(src_norm_o) < N); // R5
   AST_FAST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(src_fast_o) < N); // R5
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pend_i    (pend_i),
   .mask_i    (mask_i),
   .fast_sel_i(fast_sel_i),
   .cap_norm_i(cap_norm_i),
   .cap_fast_i(cap_fast_i),
   .src_norm_o(src_norm_o),
   .src_fast_o(src_fast_o)
);

// File: tb/irq_prio_arbiter_bench.sv
`timescale 1ns/1ps
module irq_prio_arbiter_bench;
   localparam int NB = 3;
   localparam int PW = 6;
   localparam int N  = NB * 32;
   localparam int IW = $clog2(N);

   typedef struct packed {
      logic [6:0] idx;
      logic [5:0] pr;
      logic       fs;
      logic       pd;
      logic       mk;
   } line_t;

   typedef struct packed {
      logic       fill;
      line_t      l0;
      line_t      l1;
      line_t      l2;
      logic [6:0] en;
      logic [6:0] ef;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{1'b0, '{7'd0,6'd0,1'b0,1'b0,1'b0}, '{7'd1,6'd0,1'b0,1'b0,1'b0}, '{7'd2,6'd0,1'b0,1'b0,1'b0}, 7'd0, 7'd0},
      '{1'b0, '{7'd5,6'd10,1'b0,1'b1,1'b0}, '{7'd1,6'd0,1'b0,1'b0,1'b0}, '{7'd2,6'd0,1'b0,1'b0,1'b0}, 7'd5, 7'd0},
      '{1'b0, '{7'd40,6'd3,1'b1,1'b1,1'b0}, '{7'd1,6'd0,1'b0,1'b0,1'b0}, '{7'd2,6'd0,1'b0,1'b0,1'b0}, 7'd0, 7'd40},
      '{1'b0, '{7'd10,6'd8,1'b0,1'b1,1'b0}, '{7'd70,6'd2,1'b0,1'b1,1'b0}, '{7'd33,6'd20,1'b1,1'b1,1'b0}, 7'd70, 7'd33},
      '{1'b0, '{7'd10,6'd4,1'b0,1'b1,1'b0}, '{7'd70,6'd4,1'b0,1'b1,1'b0}, '{7'd90,6'd4,1'b0,1'b1,1'b0}, 7'd90, 7'd0},
      '{1'b0, '{7'd90,6'd1,1'b0,1'b1,1'b1}, '{7'd12,6'd9,1'b0,1'b1,1'b0}, '{7'd2,6'd0,1'b0,1'b0,1'b0}, 7'd12, 7'd0},
      '{1'b1, '{7'd50,6'd0,1'b0,1'b0,1'b0}, '{7'd50,6'd0,1'b0,1'b0,1'b0}, '{7'd50,6'd0,1'b0,1'b0,1'b0}, 7'd95, 7'd0},
      '{1'b1, '{7'd3,6'd0,1'b0,1'b1,1'b0}, '{7'd50,6'd0,1'b0,1'b0,1'b0}, '{7'd50,6'd0,1'b0,1'b0,1'b0}, 7'd3, 7'd0},
      '{1'b1, '{7'd64,6'd0,1'b1,1'b1,1'b0}, '{7'd95,6'd0,1'b1,1'b1,1'b1}, '{7'd50,6'd0,1'b0,1'b0,1'b0}, 7'd94, 7'd64},
      '{1'b0, '{7'd31,6'd5,1'b1,1'b1,1'b0}, '{7'd32,6'd5,1'b1,1'b1,1'b0}, '{7'd63,6'd0,1'b0,1'b1,1'b0}, 7'd63, 7'd32},
      '{1'b0, '{7'd0,6'd0,1'b1,1'b1,1'b0}, '{7'd1,6'd63,1'b1,1'b1,1'b0}, '{7'd2,6'd0,1'b0,1'b0,1'b0}, 7'd0, 7'd0}
   };
   localparam string VTAG [NV] = '{"R6", "R1", "R2", "R3", "R4", "R1", "R4", "R3", "R5", "R5", "R2"};

   logic                clk = 1'b0;
   logic                rst_n;
   logic [N-1:0]        pend, mask, fast;
   logic [N*PW-1:0]     prio;
   logic                cap_n, cap_f;
   logic [IW-1:0]       src_n, src_f;
   int                  checks = 0;
   int                  fails  = 0;
   bit                  done   = 1'b0;

   always #2.5 clk = ~clk;

   irq_prio_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) u_irq_prio_arbiter (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_i    (pend),
      .mask_i    (mask),
      .fast_sel_i(fast),
      .prio_i    (prio),
      .cap_norm_i(cap_n),
      .cap_fast_i(cap_f),
      .src_norm_o(src_n),
      .src_fast_o(src_f)
   );

   task automatic chk(string req, string what, logic [IW-1:0] act, logic [IW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_inputs(bit fill);
      pend = fill ? '1 : '0;
      mask = '0;
      fast = '0;
      for (int i = 0; i < N; i++) prio[i*PW +: PW] = 6'd63;
   endtask

   task automatic put_line(line_t l);
      pend[l.idx] = l.pd;
      mask[l.idx] = l.mk;
      fast[l.idx] = l.fs;
      prio[l.idx*PW +: PW] = l.pr;
   endtask

   task automatic strobe(bit n, bit f);
      cap_n = n;
      cap_f = f;
      @(negedge clk);
      cap_n = 1'b0;
      cap_f = 1'b0;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cap_n = 1'b0;
      cap_f = 1'b0;
      clear_inputs(1'b0);
      repeat (3) @(negedge clk);
      // R8: both registers are 0 out of reset
      chk("R8", "reset norm", src_n, '0);
      chk("R8", "reset fast", src_f, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, both strobes together (R9)
      for (int v = 0; v < NV; v++) begin
         clear_inputs(VEC[v].fill);
         put_line(VEC[v].l0);
         put_line(VEC[v].l1);
         put_line(VEC[v].l2);
         strobe(1'b1, 1'b1);
         chk(VTAG[v], $sformatf("vec%0d norm", v), src_n, VEC[v].en[IW-1:0]);
         chk(VTAG[v], $sformatf("vec%0d fast R9", v), src_f, VEC[v].ef[IW-1:0]);
      end

      // R7: separate strobes
      clear_inputs(1'b0);
      put_line('{7'd20, 6'd1, 1'b0, 1'b1, 1'b0});
      put_line('{7'd21, 6'd1, 1'b1, 1'b1, 1'b0});
      strobe(1'b1, 1'b1);
      chk("R9", "setup norm", src_n, 7'd20);
      chk("R9", "setup fast", src_f, 7'd21);
      clear_inputs(1'b0);
      put_line('{7'd7, 6'd1, 1'b0, 1'b1, 1'b0});
      put_line('{7'd8, 6'd1, 1'b1, 1'b1, 1'b0});
      strobe(1'b1, 1'b0);
      chk("R7", "norm-only strobe norm", src_n, 7'd7);
      chk("R7", "norm-only strobe fast holds", src_f, 7'd21);
      strobe(1'b0, 1'b1);
      chk("R7", "fast-only strobe fast", src_f, 7'd8);
      chk("R7", "fast-only strobe norm holds", src_n, 7'd7);
      clear_inputs(1'b0);
      put_line('{7'd80, 6'd0, 1'b0, 1'b1, 1'b0});
      put_line('{7'd81, 6'd0, 1'b1, 1'b1, 1'b0});
      repeat (4) @(negedge clk);
      chk("R7", "no strobe norm holds", src_n, 7'd7);
      chk("R7", "no strobe fast holds", src_f, 7'd8);

      // R3: masking the urgent line hands the win to the next one (R1)
      put_line('{7'd60, 6'd2, 1'b0, 1'b1, 1'b0});
      mask[80] = 1'b1;
      strobe(1'b1, 1'b0);
      chk("R3", "masked urgent line skipped", src_n, 7'd60);

      // R8: reset in mid-run clears both registers
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8", "mid reset norm", src_n, '0);
      chk("R8", "mid reset fast", src_f, '0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule